// File: doc/BRIEF.md
# Programmable PI Loop Filter

This block is the proportional-integral filter of a clock-recovery loop. Each clock it takes a signed phase-error sample and produces a signed control word. The word is the proportional gain times the error plus the contents of an integrator. Both gains are powers of two, so each branch is a shift rather than a multiplier. The integrator holds 16 signed bits, of which the low 7 are fraction. The control word uses the same fixed-point scale. The integrator advances only on cycles where an external sample strobe is high, so the rate of that strobe sets the time constant of the integral branch.

One 8-bit configuration port serves two purposes, and its top bit selects between them. With the top bit clear, a write presets the integer part of the integrator. With the top bit set, a write loads the two gain codes. The read data always shows the integer part of the integrator, clamped to a signed 7-bit field. An integral gain of zero freezes the integrator. A preset value then acts as a constant offset on the output.

Top module: `pi_loop_filter`

## Requirements
- R1: On synchronous reset the integrator is cleared, the proportional code becomes 010 (gain 1) and the integral code becomes 0000 (gain 0). Both `ctrl_out` and `cfg_rdata` are then 0.
- R2: A write with `cfg_wdata[7]`=0 loads the integrator with the signed value in `cfg_wdata[6:0]` times 128 (fraction bits cleared). It leaves both gain codes unchanged.
- R3: A write with `cfg_wdata[7]`=1 loads the proportional code from `cfg_wdata[6:4]` and the integral code from `cfg_wdata[3:0]`. The integrator is not changed.
- R4: Proportional codes 000, 001, 010, 011 and 100 give gains 4, 2, 1, 1/2 and 1/4. Codes 101 to 111 give 1/4. The proportional term is the error times 512 / 2^code, in output units.
- R5: Integral code 0000, and codes 1001 to 1111, give zero gain: the integrator keeps its value on every cycle.
- R6: For integral code k in 1 to 8, each cycle with `sample_en`=1 adds error times 2^(8-k) to the integrator (gain 1 down to 1/128). With `sample_en`=0 the integrator keeps its value.
- R7: The integrator saturates at +32767 and -32768 and never wraps.
- R8: One clock after the inputs, `ctrl_out` equals the sum of the proportional term and the integrator value of that cycle, saturated to 16 signed bits. The proportional term uses the error and the proportional code of that cycle.
- R9: One clock after the inputs, `cfg_rdata[6:0]` holds floor(integrator / 128) of that cycle, clamped to -64..63, and `cfg_rdata[7]` is 0.
- R10: When a preset write and `sample_en` fall in the same cycle, the preset wins and no accumulation takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_in | input | ERR_W (8) | Signed phase-error sample |
| sample_en | input | 1 | Integrator update strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Clamped integer part of the integrator, registered |
| ctrl_out | output | ACC_W (16) | Signed control word, 7 fraction bits, registered |

## Verification
The assertions assume that `err_in`, `sample_en`, `cfg_we` and `cfg_wdata` are synchronous and hold steady around the rising edge. They also assume reset is held for at least one edge before any check counts, so that every `$past` value comes from a cycle the design has already seen. The stimulus drives every input only on the falling edge and keeps reset high from time zero. It covers every gain code, including the reserved ones. Long runs of extreme errors push the integrator into both saturation limits. A preset write is placed on the same cycle as a sample strobe.

// File: rtl/pi_lf_pkg.sv
`timescale 1ns/1ps
package pi_lf_pkg;
  localparam int CFG_W      = 8;
  localparam int PRE_W      = 7;
  localparam int KP_W       = 3;
  localparam int KI_W       = 4;
  localparam int KP_LAST    = 4;
  localparam int KI_LAST    = 8;
  localparam logic [KP_W-1:0] KP_RST = 3'd2;
  localparam logic [KI_W-1:0] KI_RST = 4'd0;

  typedef struct packed {
    logic [KP_W-1:0] kp;
    logic [KI_W-1:0] ki;
  } gain_codes_t;
endpackage

// File: rtl/pi_sat.sv
`timescale 1ns/1ps
module pi_sat #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic signed [IN_W-1:0] HI = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO = ~HI;

  always_comb begin
    if (din > HI)      dout = HI[OUT_W-1:0];
    else if (din < LO) dout = LO[OUT_W-1:0];
    else               dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/pi_gain_regs.sv
`timescale 1ns/1ps
module pi_gain_regs
  import pi_lf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [2:0]       kp_shift,
  output logic             ki_on,
  output logic [2:0]       ki_shift
);
  gain_codes_t codes_q;
  logic        gain_wr;

  assign gain_wr = cfg_we && cfg_wdata[CFG_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      codes_q.kp <= KP_RST;
      codes_q.ki <= KI_RST;
    end else if (gain_wr) begin
      codes_q.kp <= cfg_wdata[6:4];
      codes_q.ki <= cfg_wdata[3:0];
    end
  end

  always_comb begin
    kp_shift = (codes_q.kp > 3'(KP_LAST)) ? 3'(KP_LAST) : codes_q.kp;
    ki_on    = (codes_q.ki != '0) && (codes_q.ki <= 4'(KI_LAST));
    ki_shift = ki_on ? 3'(codes_q.ki - 4'd1) : 3'd0;
  end

  // R3
  gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !gain_wr |=> $stable(codes_q));
endmodule

// File: rtl/pi_integrator.sv
`timescale 1ns/1ps
module pi_integrator
  import pi_lf_pkg::*;
#(
  parameter int ERR_W  = 8,
  parameter int ACC_W  = 16,
  parameter int FRAC_W = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ERR_W-1:0] err,
  input  logic                    sample_en,
  input  logic                    preset_en,
  input  logic [PRE_W-1:0]        preset_val,
  input  logic                    ki_on,
  input  logic [2:0]              ki_shift,
  output logic signed [ACC_W-1:0] integ_q
);
  localparam int WIDE = ACC_W + ERR_W + FRAC_W + 2;
  localparam int EXT  = ACC_W - FRAC_W - PRE_W;

  logic signed [WIDE-1:0]  err_w, step_w, sum_w;
  logic signed [ACC_W-1:0] sum_sat, preset_w;

  always_comb begin
    err_w    = {{(WIDE-ERR_W){err[ERR_W-1]}}, err};
    step_w   = (err_w <<< FRAC_W) >>> ki_shift;
    sum_w    = {{(WIDE-ACC_W){integ_q[ACC_W-1]}}, integ_q} + step_w;
    preset_w = {{EXT{preset_val[PRE_W-1]}}, preset_val, {FRAC_W{1'b0}}};
  end

  pi_sat #(.IN_W(WIDE), .OUT_W(ACC_W)) u_sat (.din(sum_w), .dout(sum_sat));

  always_ff @(posedge clk) begin
    if (rst)                       integ_q <= '0;
    else if (preset_en)            integ_q <= preset_w;
    else if (sample_en && ki_on)   integ_q <= sum_sat;
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && !sample_en) |=> $stable(integ_q));
  // R5
  ki_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && !ki_on) |=> $stable(integ_q));
  // R2
  preset_load_chk: assert property (@(posedge clk) disable iff (rst)
    preset_en |=> ($signed(integ_q[ACC_W-1:FRAC_W]) == $signed($past(preset_val)))
                  && (integ_q[FRAC_W-1:0] == '0));
  // R7
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && sample_en && ki_on && err > 0) |=> integ_q >= $past(integ_q));
  // R7
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && sample_en && ki_on && err < 0) |=> integ_q <= $past(integ_q));
endmodule

// File: rtl/pi_out_stage.sv
`timescale 1ns/1ps
module pi_out_stage
  import pi_lf_pkg::*;
#(
  parameter int ERR_W  = 8,
  parameter int ACC_W  = 16,
  parameter int FRAC_W = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ERR_W-1:0] err,
  input  logic [2:0]              kp_shift,
  input  logic signed [ACC_W-1:0] integ,
  output logic signed [ACC_W-1:0] y_q,
  output logic [CFG_W-1:0]        rd_q
);
  localparam int WIDE  = ACC_W + ERR_W + FRAC_W + 4;
  localparam int INT_W = ACC_W - FRAC_W;

  logic signed [WIDE-1:0]  err_w, prop_w, sum_w;
  logic signed [ACC_W-1:0] y_sat;
  logic signed [INT_W-1:0] int_part;
  logic signed [PRE_W-1:0] rd_sat;

  always_comb begin
    err_w    = {{(WIDE-ERR_W){err[ERR_W-1]}}, err};
    prop_w   = (err_w <<< (FRAC_W + 2)) >>> kp_shift;
    sum_w    = prop_w + {{(WIDE-ACC_W){integ[ACC_W-1]}}, integ};
    int_part = integ[ACC_W-1:FRAC_W];
  end

  pi_sat #(.IN_W(WIDE),  .OUT_W(ACC_W)) u_ysat  (.din(sum_w),    .dout(y_sat));
  pi_sat #(.IN_W(INT_W), .OUT_W(PRE_W)) u_rdsat (.din(int_part), .dout(rd_sat));

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q  <= '0;
      rd_q <= '0;
    end else begin
      y_q  <= y_sat;
      rd_q <= {1'b0, rd_sat};
    end
  end

  // R8
  out_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (err >= 0 && integ >= 0) |=> y_q >= 0);
  // R8
  out_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (err < 0 && integ < 0) |=> y_q < 0);
endmodule

// File: rtl/pi_loop_filter.sv
`timescale 1ns/1ps
module pi_loop_filter
  import pi_lf_pkg::*;
#(
  parameter int ERR_W  = 8,
  parameter int ACC_W  = 16,
  parameter int FRAC_W = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic                    sample_en,
  input  logic                    cfg_we,
  input  logic [CFG_W-1:0]        cfg_wdata,
  output logic [CFG_W-1:0]        cfg_rdata,
  output logic signed [ACC_W-1:0] ctrl_out
);
  logic                    preset_en;
  logic [2:0]              kp_shift, ki_shift;
  logic                    ki_on;
  logic signed [ACC_W-1:0] integ;

  assign preset_en = cfg_we && !cfg_wdata[CFG_W-1];

  pi_gain_regs u_gain (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .kp_shift(kp_shift), .ki_on(ki_on), .ki_shift(ki_shift)
  );

  pi_integrator #(.ERR_W(ERR_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_integ (
    .clk(clk), .rst(rst), .err(err_in), .sample_en(sample_en),
    .preset_en(preset_en), .preset_val(cfg_wdata[PRE_W-1:0]),
    .ki_on(ki_on), .ki_shift(ki_shift), .integ_q(integ)
  );

  pi_out_stage #(.ERR_W(ERR_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_out (
    .clk(clk), .rst(rst), .err(err_in), .kp_shift(kp_shift),
    .integ(integ), .y_q(ctrl_out), .rd_q(cfg_rdata)
  );

  // R10
  preset_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (preset_en && sample_en) |=> integ[FRAC_W-1:0] == '0);
endmodule

// File: tb/pi_loop_filter_tb.sv
`timescale 1ns/1ps
module pi_loop_filter_tb_top;
  localparam int ERR_W = 8;
  localparam int ACC_W = 16;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic signed [ERR_W-1:0] err_in = '0;
  logic                    sample_en = 1'b0;
  logic                    cfg_we = 1'b0;
  logic [7:0]              cfg_wdata = '0;
  logic [7:0]              cfg_rdata;
  logic signed [ACC_W-1:0] ctrl_out;

  int total = 0;
  int bad = 0;
  bit chk_en = 0;
  string cur_req = "R1";

  pi_loop_filter dut_i (
    .clk(clk), .rst(rst), .err_in(err_in), .sample_en(sample_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctrl_out(ctrl_out)
  );

  always #10 clk = ~clk;

  function automatic int clampi(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // behavioural reference model
  int m_int, m_kp, m_ki, m_y, m_rd;
  always @(posedge clk) begin
    int e, kc;
    if (rst) begin
      m_int = 0; m_kp = 2; m_ki = 0; m_y = 0; m_rd = 0;
    end else begin
      e  = int'(err_in);
      kc = (m_kp > 4) ? 4 : m_kp;
      m_y  = clampi(e * (1 << (9 - kc)) + m_int, -32768, 32767);
      m_rd = clampi(m_int >>> 7, -64, 63);
      if (cfg_we && !cfg_wdata[7])
        m_int = int'($signed(cfg_wdata[6:0])) * 128;
      else if (sample_en && m_ki >= 1 && m_ki <= 8)
        m_int = clampi(m_int + e * (1 << (8 - m_ki)), -32768, 32767);
      if (cfg_we && cfg_wdata[7]) begin
        m_kp = int'(cfg_wdata[6:4]);
        m_ki = int'(cfg_wdata[3:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      total++;
      if (int'(ctrl_out) != m_y) begin
        bad++;
        $display("FAIL %s ctrl_out actual=%0d expected=%0d", cur_req, ctrl_out, m_y);
      end
      total++;
      if (cfg_rdata != {1'b0, 7'(m_rd)}) begin
        bad++;
        $display("FAIL R9 cfg_rdata actual=%0h expected=%0h", cfg_rdata, {1'b0, 7'(m_rd)});
      end
    end
  end

  task automatic drive(input int e, input bit s, input bit we, input logic [7:0] wd);
    @(negedge clk);
    err_in = e[ERR_W-1:0]; sample_en = s; cfg_we = we; cfg_wdata = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00);
  endtask

  function automatic int rnd_err();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk_en = 1;           // R1: reset values observed while reset is held
    @(negedge clk); rst = 1'b0;
    cur_req = "R1";       // default gain 1, integral off
    drive(10, 0, 0, 8'h00);
    drive(-7, 1, 0, 8'h00);
    idle(2);
    cur_req = "R5";
    for (int i = 0; i < 20; i++) drive(rnd_err(), 1, 0, 8'h00);
    cur_req = "R2";
    drive(0, 0, 1, 8'h25); idle(3);
    drive(0, 0, 1, 8'h5A); idle(3);
    drive(5, 0, 1, 8'h3F); idle(3);
    drive(-5, 0, 1, 8'h40); idle(3);
    cur_req = "R4";
    for (int c = 0; c < 8; c++) begin
      drive(0, 0, 1, {1'b1, 3'(c), 4'b0000});
      for (int i = 0; i < 5; i++) drive(rnd_err(), 1, 0, 8'h00);
      drive(127, 0, 0, 8'h00); drive(-128, 0, 0, 8'h00);
    end
    cur_req = "R3";
    drive(0, 0, 1, 8'h11);
    drive(0, 0, 1, 8'hA3);
    idle(3);
    drive(0, 0, 1, 8'hF0);
    idle(3);
    cur_req = "R6";
    for (int k = 0; k < 16; k++) begin
      drive(0, 0, 1, {4'b1010, 4'(k)});
      drive(0, 0, 1, 8'h00);
      for (int i = 0; i < 12; i++) drive(rnd_err() / 8, bit'($urandom_range(0, 1)), 0, 8'h00);
      idle(2);
    end
    cur_req = "R7";
    drive(0, 0, 1, 8'hA1);
    for (int i = 0; i < 40; i++) drive(127, 1, 0, 8'h00);
    for (int i = 0; i < 80; i++) drive(-128, 1, 0, 8'h00);
    for (int i = 0; i < 5; i++) drive(-128, 0, 0, 8'h00);
    cur_req = "R10";
    drive(0, 0, 1, 8'hA1);
    drive(100, 1, 1, 8'h0A); idle(2);
    drive(-90, 1, 1, 8'h7C); idle(2);
    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 19) == 0)
        drive(rnd_err(), bit'($urandom_range(0, 1)), 1, 8'($urandom_range(0, 255)));
      else
        drive(rnd_err(), bit'($urandom_range(0, 1)), 0, 8'h00);
    end
    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule